// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell Unit

This unit holds sixteen 32-bit doorbell mailboxes, four belonging to each of four processor cores. Every bit in a mailbox is an independent doorbell. Any requester on one of the write ports can ring doorbells in any mailbox by writing a mask to the mailbox's ring address, and the mask is ORed into what is already pending. The core that owns the mailbox reads the pending bits through the mailbox's acknowledge address and retires the ones it has handled by writing a mask back to that same address. Up to 32 distinct messages can therefore wait in one mailbox, and each one is retired on its own.

Each mailbox drives a pending flag that is high while any of its bits is set. An interrupt router further along the chip consumes these flags and decides which of them reach a core. Enabling and routing are not done here. Several write ports can reach the same mailbox in the same cycle. When one port rings a bit and another acknowledges the same bit in that cycle, the ring is kept, so no doorbell is lost.

The address space is split into four windows by the two top address bits: `WIN_RSVD0` and `WIN_RSVD1` (00, 01) are ignored, `WIN_SET` (10) rings doorbells, and `WIN_CLR` (11) reads and acknowledges them. Within a window, address bits [5:2] select mailbox 4*core + slot, and bits [1:0] must be zero.

Top module: `mbx_doorbell_unit`

## Requirements
- R1: While reset is held and after it is released, every mailbox is zero, every pending flag is low and rd_data is zero.
- R2: A write to address 0x80 + 16*core + 4*slot ORs the write data into mailbox 4*core + slot, keeping earlier bits. The result is visible on the pending flag and through a read on the cycle after the write edge.
- R3: A write to address 0xC0 + 16*core + 4*slot clears exactly those bits of mailbox 4*core + slot that are 1 in the write data, and leaves every other bit unchanged.
- R4: A read with rd_valid of the acknowledge address 0xC0 + 16*core + 4*slot loads rd_data at that clock edge with the mailbox contents as they were before any write in the same cycle. rd_data holds its value when rd_valid is low.
- R5: A read of a ring address (0x80 to 0xBF), of an address below 0x80, or of an address with bits [1:0] not zero returns zero.
- R6: A write changes only the mailbox it addresses. Writes below 0x80, or with address bits [1:0] not zero, change no mailbox.
- R7: mbox_pending[k] is high exactly while mailbox k is nonzero. It stays high after a partial acknowledge and falls only after an acknowledge write that leaves the mailbox empty.
- R8: When a ring and an acknowledge reach the same mailbox bit in the same cycle, whether from the same or different ports, the bit ends up set.
- R9: When several ports ring the same mailbox in the same cycle, the mailbox receives the OR of all their masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | NUM_WR_PORTS | Per-port write strobe |
| wr_addr | input | NUM_WR_PORTS*ADDR_W | Per-port byte address, port p in bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR_PORTS*DATA_W | Per-port write mask, port p in bits [p*DATA_W +: DATA_W] |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Registered read data |
| mbox_pending | output | NUM_MBOX | One nonzero flag per mailbox, index 4*core + slot |

## Verification
A write sampled at clock edge N shows up on mbox_pending and in the mailbox contents right after edge N, so one cycle later. A read sampled at edge N loads rd_data at that same edge with the contents from before edge N. The bench drives inputs on falling edges and compares on the next falling edge, which is exactly one register stage after the sampling edge. A behavioural model updates on each rising edge from the same inputs, and every pending flag and rd_data is compared against it on every cycle. Directed reads with fixed expected constants then pin down the OR, the masked clear, the ring-wins collision and the zero returns.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Address window selected by the two top address bits.
    typedef enum logic [1:0] {
        WIN_RSVD0 = 2'b00,
        WIN_RSVD1 = 2'b01,
        WIN_SET   = 2'b10,
        WIN_CLR   = 2'b11
    } mbx_win_e;

    localparam int WORD_BYTES    = 4;
    localparam int BYTE_OFS_W    = 2;
    localparam int WIN_BITS      = 2;

    function automatic int mbx_addr_width(input int num_mbox);
        return $clog2(num_mbox * WORD_BYTES) + WIN_BITS;
    endfunction

endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter  int NUM_MBOX = 16,
    parameter  int ADDR_W   = 8,
    localparam int IDX_W    = $clog2(NUM_MBOX)
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              set_hit,
    output logic              clr_hit,
    output logic [IDX_W-1:0]  idx
);

    mbx_win_e win;
    logic     aligned;

    assign win     = mbx_win_e'(addr[ADDR_W-1 -: WIN_BITS]);
    assign aligned = (addr[BYTE_OFS_W-1:0] == '0);
    assign idx     = addr[BYTE_OFS_W +: IDX_W];

    always_comb begin
        set_hit = 1'b0;
        clr_hit = 1'b0;
        if (valid && aligned) begin
            unique case (win)
                WIN_SET:   set_hit = 1'b1;
                WIN_CLR:   clr_hit = 1'b1;
                WIN_RSVD0,
                WIN_RSVD1: ;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] q,
    output logic              pending
);

    // Ring bits are ORed after the acknowledge mask: a collision keeps the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_mask) | set_mask;
        end
    end

    assign pending = |q;

endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port #(
    parameter  int NUM_MBOX = 16,
    parameter  int DATA_W   = 32,
    localparam int IDX_W    = $clog2(NUM_MBOX)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_valid,
    input  logic                            rd_set_hit,
    input  logic                            rd_clr_hit,
    input  logic [IDX_W-1:0]                rd_idx,
    input  logic [NUM_MBOX-1:0][DATA_W-1:0] mbox_q,
    output logic [DATA_W-1:0]               rd_data
);

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        unique case ({rd_set_hit, rd_clr_hit})
            2'b01:   rd_next = mbox_q[rd_idx];
            2'b10:   rd_next = '0;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_valid) begin
            rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/mbx_doorbell_unit.sv
module mbx_doorbell_unit
    import mbx_pkg::*;
#(
    parameter  int NUM_CORES     = 4,
    parameter  int MBOX_PER_CORE = 4,
    parameter  int DATA_W        = 32,
    parameter  int NUM_WR_PORTS  = 2,
    localparam int NUM_MBOX      = NUM_CORES * MBOX_PER_CORE,
    localparam int ADDR_W        = mbx_addr_width(NUM_MBOX)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WR_PORTS-1:0]          wr_valid,
    input  logic [NUM_WR_PORTS*ADDR_W-1:0]   wr_addr,
    input  logic [NUM_WR_PORTS*DATA_W-1:0]   wr_data,
    input  logic                             rd_valid,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_MBOX-1:0]              mbox_pending
);

    localparam int IDX_W = $clog2(NUM_MBOX);

    logic [NUM_WR_PORTS-1:0]                port_set;
    logic [NUM_WR_PORTS-1:0]                port_clr;
    logic [NUM_WR_PORTS-1:0][IDX_W-1:0]     port_idx;
    logic [NUM_MBOX-1:0][DATA_W-1:0]        set_mask;
    logic [NUM_MBOX-1:0][DATA_W-1:0]        clr_mask;
    logic [NUM_MBOX-1:0][DATA_W-1:0]        mbox_q;
    logic                                   rd_set_hit;
    logic                                   rd_clr_hit;
    logic [IDX_W-1:0]                       rd_idx;

    // One address decoder per write port.
    for (genvar p = 0; p < NUM_WR_PORTS; p++) begin : g_wr_dec
        mbx_addr_dec #(
            .NUM_MBOX (NUM_MBOX),
            .ADDR_W   (ADDR_W)
        ) u_dec (
            .valid   (wr_valid[p]),
            .addr    (wr_addr[p*ADDR_W +: ADDR_W]),
            .set_hit (port_set[p]),
            .clr_hit (port_clr[p]),
            .idx     (port_idx[p])
        );
    end

    // Merge every port's masks per mailbox.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int p = 0; p < NUM_WR_PORTS; p++) begin
            if (port_set[p]) begin
                set_mask[port_idx[p]] = set_mask[port_idx[p]] | wr_data[p*DATA_W +: DATA_W];
            end
            if (port_clr[p]) begin
                clr_mask[port_idx[p]] = clr_mask[port_idx[p]] | wr_data[p*DATA_W +: DATA_W];
            end
        end
    end

    // Mailbox storage.
    for (genvar k = 0; k < NUM_MBOX; k++) begin : g_mbox
        mbx_cell #(
            .DATA_W (DATA_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_mask[k]),
            .clr_mask (clr_mask[k]),
            .q        (mbox_q[k]),
            .pending  (mbox_pending[k])
        );
    end

    // Read path.
    mbx_addr_dec #(
        .NUM_MBOX (NUM_MBOX),
        .ADDR_W   (ADDR_W)
    ) u_rd_dec (
        .valid   (rd_valid),
        .addr    (rd_addr),
        .set_hit (rd_set_hit),
        .clr_hit (rd_clr_hit),
        .idx     (rd_idx)
    );

    mbx_read_port #(
        .NUM_MBOX (NUM_MBOX),
        .DATA_W   (DATA_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_valid   (rd_valid),
        .rd_set_hit (rd_set_hit),
        .rd_clr_hit (rd_clr_hit),
        .rd_idx     (rd_idx),
        .mbox_q     (mbox_q),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
    parameter  int NUM_MBOX     = 16,
    parameter  int DATA_W       = 32,
    parameter  int NUM_WR_PORTS = 2,
    parameter  int ADDR_W       = 8,
    localparam int IDX_W        = $clog2(NUM_MBOX)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_WR_PORTS-1:0]        wr_valid,
    input logic [NUM_WR_PORTS*ADDR_W-1:0] wr_addr,
    input logic [NUM_WR_PORTS*DATA_W-1:0] wr_data,
    input logic                           rd_valid,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic [DATA_W-1:0]              rd_data,
    input logic [NUM_MBOX-1:0]            mbox_pending
);

    logic [NUM_WR_PORTS-1:0]            c_set;
    logic [NUM_WR_PORTS-1:0]            c_clr;
    logic [NUM_WR_PORTS-1:0][IDX_W-1:0] c_idx;
    logic [NUM_MBOX-1:0]                clr_touch;

    always_comb begin
        clr_touch = '0;
        for (int p = 0; p < NUM_WR_PORTS; p++) begin
            c_set[p] = wr_valid[p] && (wr_addr[p*ADDR_W + ADDR_W - 1 -: 2] == 2'b10)
                       && (wr_addr[p*ADDR_W +: 2] == 2'b00);
            c_clr[p] = wr_valid[p] && (wr_addr[p*ADDR_W + ADDR_W - 1 -: 2] == 2'b11)
                       && (wr_addr[p*ADDR_W +: 2] == 2'b00);
            c_idx[p] = wr_addr[p*ADDR_W + 2 +: IDX_W];
            if (c_clr[p]) clr_touch[c_idx[p]] = 1'b1;
        end
    end

    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (mbox_pending == '0) && (rd_data == '0));

    p_set_addr_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (rd_addr[ADDR_W-1 -: 2] != 2'b11)) |=> (rd_data == '0));

    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid == '0) |=> $stable(mbox_pending));

    for (genvar p = 0; p < NUM_WR_PORTS; p++) begin : g_port
        // Covers R2 and R8: a nonzero ring always leaves the mailbox pending.
        p_ring_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (c_set[p] && (wr_data[p*DATA_W +: DATA_W] != '0)) |=> mbox_pending[$past(c_idx[p])]);
    end

    for (genvar k = 0; k < NUM_MBOX; k++) begin : g_mbox
        p_fall_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(mbox_pending[k]) |-> $past(clr_touch[k]));
    end

endmodule

bind mbx_doorbell_unit mbx_doorbell_chk #(
    .NUM_MBOX     (NUM_MBOX),
    .DATA_W       (DATA_W),
    .NUM_WR_PORTS (NUM_WR_PORTS),
    .ADDR_W       (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_valid     (rd_valid),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .mbox_pending (mbox_pending)
);

// File: tb/tb_mbx_doorbell_unit.sv
`timescale 1ns/1ps
module tb_mbx_doorbell_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_valid = '0;
    logic [15:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] mbox_pending;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] mdl [16];
    logic [31:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    mbx_doorbell_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_data(rd_data), .mbox_pending(mbox_pending)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    always @(posedge clk) begin
        logic [31:0] s [16];
        logic [31:0] c [16];
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) mdl[k] = '0;
            exp_rd = '0;
        end else begin
            if (rd_valid)
                exp_rd = (rd_addr[7:6] == 2'b11 && rd_addr[1:0] == 2'b00) ? mdl[rd_addr[5:2]] : 32'h0;
            for (int k = 0; k < 16; k++) begin s[k] = '0; c[k] = '0; end
            for (int p = 0; p < 2; p++) begin
                logic [7:0]  a;
                logic [31:0] d;
                a = wr_addr[p*8 +: 8];
                d = wr_data[p*32 +: 32];
                if (wr_valid[p] && a[1:0] == 2'b00) begin
                    if (a[7:6] == 2'b10) s[a[5:2]] = s[a[5:2]] | d;
                    if (a[7:6] == 2'b11) c[a[5:2]] = c[a[5:2]] | d;
                end
            end
            for (int k = 0; k < 16; k++) mdl[k] = (mdl[k] & ~c[k]) | s[k];
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int k = 0; k < 16; k++)
                check($sformatf("R7 flag %0d vs model", k), {31'b0, mbox_pending[k]}, {31'b0, mdl[k] != 0});
            check("R4 rd_data vs model", rd_data, exp_rd);
        end
    end

    task automatic drive(input logic v0, input logic [7:0] a0, input logic [31:0] d0,
                         input logic v1, input logic [7:0] a1, input logic [31:0] d1,
                         input logic rv, input logic [7:0] ra);
        @(negedge clk);
        wr_valid = {v1, v0};
        wr_addr  = {a1, a0};
        wr_data  = {d1, d0};
        rd_valid = rv;
        rd_addr  = ra;
    endtask

    task automatic idle();
        wr_valid = '0;
        rd_valid = 1'b0;
    endtask

    task automatic wr0(input logic [7:0] a, input logic [31:0] d);
        drive(1, a, d, 0, 8'h0, 32'h0, 0, 8'h0);
        @(negedge clk);
        idle();
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        drive(0, 8'h0, 32'h0, 0, 8'h0, 32'h0, 1, a);
        @(negedge clk);
        check(tag, rd_data, exp);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 flags in reset", {16'h0, mbox_pending}, 32'h0);
        check("R1 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", {16'h0, mbox_pending}, 32'h0);
        rd_check("R1 empty mailbox 0", 8'hC0, 32'h0);

        // R2: core 1 slot 2 -> index 6 at 0x98.
        wr0(8'h98, 32'h5);
        check("R2 R6 only flag 6", {16'h0, mbox_pending}, 32'h0000_0040);
        rd_check("R2 ring value", 8'hD8, 32'h5);
        wr0(8'h98, 32'h100);
        rd_check("R2 OR keeps earlier bits", 8'hD8, 32'h105);
        // R2: core 2 slot 1 -> index 9 at 0xA4.
        wr0(8'hA4, 32'h8);
        check("R2 index 4c+m", {16'h0, mbox_pending}, 32'h0000_0240);
        rd_check("R2 index 9 value", 8'hE4, 32'h8);

        // R3 / R7: partial acknowledge through port 1.
        drive(0, 8'h0, 32'h0, 1, 8'hD8, 32'h4, 0, 8'h0);
        @(negedge clk);
        idle();
        check("R7 flag stays after partial ack", {31'b0, mbox_pending[6]}, 32'h1);
        rd_check("R3 masked clear", 8'hD8, 32'h101);
        wr0(8'hD8, 32'h101);
        check("R7 flag falls when empty", {31'b0, mbox_pending[6]}, 32'h0);
        rd_check("R3 fully cleared", 8'hD8, 32'h0);
        wr0(8'hE4, 32'h8);

        // R8: ring and ack on the same bits in one cycle.
        wr0(8'h8C, 32'h0F);
        drive(1, 8'h8C, 32'hF0, 1, 8'hCC, 32'hFF, 0, 8'h0);
        @(negedge clk);
        idle();
        rd_check("R8 ring wins over ack", 8'hCC, 32'hF0);

        // R6: ignored writes.
        wr0(8'h9A, 32'hFF);
        wr0(8'h40, 32'hFF);
        wr0(8'h00, 32'hFF);
        check("R6 ignored writes", {16'h0, mbox_pending}, 32'h0000_0008);
        rd_check("R6 mailbox 6 untouched", 8'hD8, 32'h0);

        // R5: zero-returning reads.
        rd_check("R5 read of ring address", 8'h8C, 32'h0);
        rd_check("R5 misaligned read", 8'hCE, 32'h0);
        rd_check("R5 low window read", 8'h1C, 32'h0);

        // R9: two rings in one cycle on index 15.
        drive(1, 8'hBC, 32'h1, 1, 8'hBC, 32'h8000_0000, 0, 8'h0);
        @(negedge clk);
        idle();
        check("R9 flags", {16'h0, mbox_pending}, 32'h0000_8008);
        rd_check("R9 OR of ports", 8'hFC, 32'h8000_0001);

        // R4: read sees value before the same-cycle write.
        drive(1, 8'h8C, 32'h100, 0, 8'h0, 32'h0, 1, 8'hCC);
        @(negedge clk);
        check("R4 old value on concurrent write", rd_data, 32'hF0);
        idle();
        rd_check("R4 new value after write", 8'hCC, 32'h1F0);
        @(negedge clk);
        check("R4 rd_data holds without read", rd_data, 32'h1F0);

        // Mixed traffic compared against the model every cycle.
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a0, a1, ra;
            a0 = {1'b1, 7'($urandom)} & (($urandom % 8 == 0) ? 8'hFF : 8'hFC);
            a1 = {1'b1, 7'($urandom)} & 8'hFC;
            ra = 8'($urandom) & 8'hFC;
            if ($urandom % 2 == 0) ra[7:6] = 2'b11;
            drive(1'($urandom), a0, $urandom & $urandom, 1'($urandom), a1, $urandom, 1'($urandom), ra);
        end
        @(negedge clk);
        idle();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule